// File: doc/BRIEF.md
# Jitter Attenuating Elastic Buffer

This block smooths the timing of recovered line data. Each recovered symbol, a bipolar positive/negative pair, is written into a small ring buffer on a write strobe that marks the recovered line clock. Symbols leave the buffer on a smoothed read strobe. That strobe comes from a divider running on a clock at twice the local oscillator rate. The divider counts eight cycles per output period, which is four oscillator cycles. Jitter on the write side is absorbed by the buffer fill.

The block tracks the fill level, meaning the distance between the write and read pointers. It turns the fill into a two-bit steering code that asks for a faster or slower oscillator. When the pointers come close to crossing, the divider makes one period shorter (seven counts, 3.5 oscillator cycles) or longer (nine counts, 4.5 oscillator cycles) so that no data is lost.

A bypass input takes the buffer and divider out of use. In bypass the output strobe follows an externally supplied line-rate strobe, and the output symbol is captured straight from the line inputs.

Top module: `jitter_elastic_buf`

## Requirements
- R1: While reset is held and right after it, `rd_stb`, `rx_pos`, `rx_neg` and `pull` are 0. The buffer holds DEPTH/2 (16) all-zero symbols, so the fill starts at 16. The first `rd_stb` appears on the 8th rising edge after reset is released.
- R2: Each cycle with `wr_stb` high outside bypass stores {`line_pos`,`line_neg`}. Symbols leave in write order. When the divider ends a period, the next symbol appears on `rx_pos`/`rx_neg` one cycle later, in the same cycle that `rd_stb` is high.
- R3: The fill is the number of writes minus the number of reads since the last reset or bypass exit, plus 16. If the fill is between 3 and 29 at the edge that ends a period, the next period lasts 8 clock cycles.
- R4: If the fill is 30 or more (DEPTH-GUARD) at the edge that ends a period, the next period is shortened to 7 cycles.
- R5: If the fill is 2 or less (GUARD) at the edge that ends a period, the next period is stretched to 9 cycles.
- R6: A period's length is fixed at the edge that starts it, so there is at most one slip per period. `rd_stb` is never missing at the end of that length and never early.
- R7: `pull` is registered from the fill before each edge. It is 2'b01 (speed up) when the fill is above 18, 2'b10 (slow down) when the fill is below 14, and 2'b00 otherwise.
- R8: While `bypass` is high, `rd_stb` equals `ext_stb` one cycle later. An edge with `ext_stb` high loads {`line_pos`,`line_neg`} into the outputs, and `pull` is 2'b00.
- R9: While `bypass` is high, writes are ignored and the buffer and divider are held in their reset state. After bypass drops, 16 zero symbols are read first, and the first `rd_stb` comes on the 8th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the local oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Recovered line clock strobe, one write per high cycle |
| line_pos | input | 1 | Recovered positive rail |
| line_neg | input | 1 | Recovered negative rail |
| bypass | input | 1 | Use the external strobe instead of the buffer |
| ext_stb | input | 1 | External line-rate strobe used in bypass |
| rd_stb | output | 1 | Smoothed receive clock strobe |
| rx_pos | output | 1 | Smoothed positive rail |
| rx_neg | output | 1 | Smoothed negative rail |
| pull | output | 2 | Oscillator steering code |

## Verification
All results are due one edge after their cause. `pull` reflects the fill held before an edge, and it shows after that edge. `rd_stb` and the output symbol show one cycle after the counting edge that ends a period, and in bypass one cycle after `ext_stb`. A period's length is the fill before the edge that produced the previous `rd_stb`. The bench drives and samples on falling edges. At each falling edge it keeps the fill the design held before the last rising edge, so pull codes, period lengths and symbol order are compared against exactly the value the design used. The write rate is swept faster and slower than the read rate, which drives the fill into both guard bands.

// File: rtl/jeb_pkg.sv
package jeb_pkg;

   typedef enum logic [1:0] {
      PULL_HOLD = 2'b00,
      PULL_UP   = 2'b01,
      PULL_DOWN = 2'b10
   } pull_e;

   typedef struct packed {
      logic pos;
      logic neg;
   } sym_t;

endpackage

// File: rtl/jeb_store.sv
module jeb_store
   import jeb_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int AW = $clog2(DEPTH),
   localparam int OW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  sym_t          wr_sym,
   input  logic          rd_en,
   output sym_t          rd_sym,
   output logic [OW-1:0] occ
);

   localparam logic [OW-1:0] HALF = OW'(DEPTH / 2);

   logic [OW-1:0] wr_ptr;
   logic [OW-1:0] rd_ptr;
   sym_t          mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= HALF;
         rd_ptr <= '0;
      end else if (clr) begin
         wr_ptr <= HALF;
         rd_ptr <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + 1'b1;
         if (rd_en) rd_ptr <= rd_ptr + 1'b1;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem[i] <= '0;
         end else if (clr) begin
            mem[i] <= '0;
         end else if (wr_en && (wr_ptr[AW-1:0] == AW'(i))) begin
            mem[i] <= wr_sym;
         end
      end
   end

   assign rd_sym = mem[rd_ptr[AW-1:0]];
   assign occ    = wr_ptr - rd_ptr;

   // R9
   occ_half_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (occ == HALF));

   // R2
   occ_grows_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en && !clr) |=> (occ == OW'($past(occ) + 1'b1)));

endmodule

// File: rtl/jeb_phase.sv
module jeb_phase
   import jeb_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int GUARD = 2,
   parameter int BAND  = 2,
   localparam int OW = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [OW-1:0] occ,
   output pull_e         pull_q,
   output logic          shorten,
   output logic          lengthen
);

   localparam logic [OW-1:0] HI_TH   = OW'(DEPTH / 2 + BAND);
   localparam logic [OW-1:0] LO_TH   = OW'(DEPTH / 2 - BAND);
   localparam logic [OW-1:0] FULL_TH = OW'(DEPTH - GUARD);
   localparam logic [OW-1:0] EMPT_TH = OW'(GUARD);

   pull_e pull_d;

   always_comb begin
      if (occ > HI_TH)      pull_d = PULL_UP;
      else if (occ < LO_TH) pull_d = PULL_DOWN;
      else                  pull_d = PULL_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pull_q <= PULL_HOLD;
      else if (clr) pull_q <= PULL_HOLD;
      else          pull_q <= pull_d;
   end

   assign shorten  = (occ >= FULL_TH);
   assign lengthen = (occ <= EMPT_TH);

   // R7
   pull_up_when_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((occ > HI_TH) && !clr) |=> (pull_q == PULL_UP));

endmodule

// File: rtl/jeb_divider.sv
module jeb_divider #(
   parameter int DIV = 4,
   localparam int NOM = 2 * DIV,
   localparam int CW  = $clog2(NOM + 2)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic shorten,
   input  logic lengthen,
   output logic tick
);

   localparam logic [CW-1:0] NOM_M1   = CW'(NOM - 1);
   localparam logic [CW-1:0] SHORT_M1 = CW'(NOM - 2);
   localparam logic [CW-1:0] LONG_M1  = CW'(NOM);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] len_q;
   logic [CW-1:0] len_d;

   assign tick = !clr && (cnt_q == len_q);

   always_comb begin
      if (shorten)       len_d = SHORT_M1;
      else if (lengthen) len_d = LONG_M1;
      else               len_d = NOM_M1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         len_q <= NOM_M1;
      end else if (clr) begin
         cnt_q <= '0;
         len_q <= NOM_M1;
      end else if (tick) begin
         cnt_q <= '0;
         len_q <= len_d;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R6
   length_fixed_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(len_q));

   // R6
   no_back_to_back_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/jitter_elastic_buf.sv
module jitter_elastic_buf
   import jeb_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int DIV   = 4,
   parameter int GUARD = 2,
   parameter int BAND  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stb,
   input  logic       line_pos,
   input  logic       line_neg,
   input  logic       bypass,
   input  logic       ext_stb,
   output logic       rd_stb,
   output logic       rx_pos,
   output logic       rx_neg,
   output logic [1:0] pull
);

   localparam int OW = $clog2(DEPTH) + 1;

   if ((DEPTH < 8) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 8");
   end
   if (DIV < 2) begin : g_bad_div
      $error("DIV must be at least 2");
   end
   if ((GUARD < 1) || (2 * GUARD + 2 >= DEPTH / 2)) begin : g_bad_guard
      $error("GUARD must be small against DEPTH/2");
   end
   if ((BAND < 0) || (BAND >= DEPTH / 2 - GUARD)) begin : g_bad_band
      $error("BAND must sit inside the guard limits");
   end

   sym_t          wr_sym;
   sym_t          rd_sym;
   logic [OW-1:0] occ;
   logic          tick;
   logic          shorten;
   logic          lengthen;
   pull_e         pull_q;

   assign wr_sym = '{pos: line_pos, neg: line_neg};

   jeb_store #(.DEPTH(DEPTH)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (bypass),
      .wr_en  (wr_stb && !bypass),
      .wr_sym (wr_sym),
      .rd_en  (tick),
      .rd_sym (rd_sym),
      .occ    (occ)
   );

   jeb_phase #(.DEPTH(DEPTH), .GUARD(GUARD), .BAND(BAND)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (bypass),
      .occ      (occ),
      .pull_q   (pull_q),
      .shorten  (shorten),
      .lengthen (lengthen)
   );

   jeb_divider #(.DIV(DIV)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (bypass),
      .shorten  (shorten),
      .lengthen (lengthen),
      .tick     (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_stb <= 1'b0;
         rx_pos <= 1'b0;
         rx_neg <= 1'b0;
      end else if (bypass) begin
         rd_stb <= ext_stb;
         if (ext_stb) begin
            rx_pos <= line_pos;
            rx_neg <= line_neg;
         end
      end else begin
         rd_stb <= tick;
         if (tick) begin
            rx_pos <= rd_sym.pos;
            rx_neg <= rd_sym.neg;
         end
      end
   end

   assign pull = pull_q;

   // R8
   bypass_strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> (rd_stb == $past(ext_stb)));

   // R8
   bypass_pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> (pull == 2'b00));

endmodule

// File: tb/tb_jitter_elastic_buf.sv
module tb_jitter_elastic_buf;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_stb = 1'b0;
   logic       line_pos = 1'b0;
   logic       line_neg = 1'b0;
   logic       bypass = 1'b0;
   logic       ext_stb = 1'b0;
   logic       rd_stb;
   logic       rx_pos;
   logic       rx_neg;
   logic [1:0] pull;

   always #2.5 clk = ~clk;

   jitter_elastic_buf dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .line_pos(line_pos),
      .line_neg(line_neg), .bypass(bypass), .ext_stb(ext_stb),
      .rd_stb(rd_stb), .rx_pos(rx_pos), .rx_neg(rx_neg), .pull(pull)
   );

   int checks = 0;
   int errors = 0;

   logic       wr_q = 1'b0, ext_q = 1'b0, byp_q = 1'b0;
   logic [1:0] din_q = 2'b00;
   int         occ_prev, since, exp_len, zeros_left, k, n7, n9;
   string      init_tag;
   logic [1:0] q[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int pull_of(input int o);
      if (o > 18) return 1;
      if (o < 14) return 2;
      return 0;
   endfunction

   function automatic int len_of(input int o);
      if (o >= 30) return 7;
      if (o <= 2) return 9;
      return 8;
   endfunction

   task automatic model_init(input string tag);
      occ_prev = 16;
      since = 0;
      exp_len = 8;
      zeros_left = 16;
      init_tag = tag;
      q.delete();
      for (int i = 0; i < 16; i++) q.push_back(2'b00);
   endtask

   task automatic tick(input logic wr, input logic ext, input logic byp);
      logic [1:0] d;
      int occ_now;
      @(negedge clk);
      if (byp_q) begin
         chk(rd_stb == ext_q, "R8 strobe", int'(rd_stb), int'(ext_q));
         if (ext_q) chk({rx_pos, rx_neg} == din_q, "R8 data", int'({rx_pos, rx_neg}), int'(din_q));
         chk(pull == 2'b00, "R8 pull", int'(pull), 0);
         model_init("R9");
      end else begin
         occ_now = occ_prev + int'(wr_q) - int'(rd_stb);
         chk(int'(pull) == pull_of(occ_prev), "R7 pull", int'(pull), pull_of(occ_prev));
         since++;
         if (rd_stb) begin
            if (init_tag != "") chk(since == exp_len, {init_tag, " first tick"}, since, exp_len);
            else if (exp_len == 7) chk(since == 7, "R4 short period", since, 7);
            else if (exp_len == 9) chk(since == 9, "R5 long period", since, 9);
            else chk(since == 8, "R3 nominal period", since, 8);
            if (exp_len == 7) n7++;
            if (exp_len == 9) n9++;
            init_tag = "";
            if (q.size() > 0) begin
               d = q.pop_front();
               if (occ_prev >= 1) begin
                  if (zeros_left > 0) chk({rx_pos, rx_neg} == d, "R1/R9 zero fill", int'({rx_pos, rx_neg}), int'(d));
                  else chk({rx_pos, rx_neg} == d, "R2 order", int'({rx_pos, rx_neg}), int'(d));
               end
               if (zeros_left > 0) zeros_left--;
            end
            exp_len = len_of(occ_prev);
            since = 0;
         end else begin
            chk(since < exp_len, "R6 missing tick", since, exp_len);
         end
         occ_prev = occ_now;
      end
      d = {k[1] ^ k[3], k[0]};
      if (wr) k++;
      if (wr && !byp) q.push_back(d);
      wr_stb = wr;
      {line_pos, line_neg} = d;
      ext_stb = ext;
      bypass = byp;
      wr_q = wr;
      ext_q = ext;
      byp_q = byp;
      din_q = d;
   endtask

   task automatic run(input int n, input int gap);
      for (int i = 0; i < n; i++) tick((i % gap) == 0, 1'b0, 1'b0);
   endtask

   initial begin : watchdog
      #200000;
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      int guard_cnt;
      k = 0; n7 = 0; n9 = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rd_stb == 1'b0, "R1 rd_stb", int'(rd_stb), 0);
      chk({rx_pos, rx_neg} == 2'b00, "R1 data", int'({rx_pos, rx_neg}), 0);
      chk(pull == 2'b00, "R1 pull", int'(pull), 0);
      rst_n = 1'b1;
      model_init("R1");

      run(400, 8);
      // fast writer pushes fill to the high guard (R4, R7)
      guard_cnt = 0;
      while (occ_prev < 30 && guard_cnt < 3000) begin
         tick((guard_cnt % 6) == 0, 1'b0, 1'b0);
         guard_cnt++;
      end
      chk(occ_prev >= 30, "R4 reach high guard", occ_prev, 30);
      run(400, 7);
      run(200, 8);
      // slow writer drains fill to the low guard (R5)
      guard_cnt = 0;
      while (occ_prev > 2 && guard_cnt < 3000) begin
         tick((guard_cnt % 10) == 0, 1'b0, 1'b0);
         guard_cnt++;
      end
      chk(occ_prev <= 2, "R5 reach low guard", occ_prev, 2);
      run(400, 9);
      run(300, 8);
      chk(n7 > 0, "R4 short seen", n7, 1);
      chk(n9 > 0, "R5 long seen", n9, 1);
      // bypass with ignored writes (R8, R9)
      for (int i = 0; i < 60; i++) tick((i % 3) == 0, (i % 8) == 2, 1'b1);
      run(300, 8);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule